// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a memory-class chip. It runs the usual sixteen-state test controller from the test clock and the mode-select line. Behind the controller sit a 3-bit instruction register, a 1-bit bypass register, a 32-bit identification register and a boundary register. The boundary register is 107 bits long by default. The boundary register loads a parallel vector of pin values that the pad ring supplies. The block also drives an output-disable line to the functional core, which puts the data outputs into high impedance.

The chip has no dedicated test-reset pin. The controller returns to its reset state in two ways: when mode-select is held high for five rising test-clock edges, or when the chip-level power-on signal is asserted. Instructions do not follow the standard set. The all-zero code captures pins the same way as the sample instruction, and it also disables the outputs. A separate sample-with-high-impedance code also disables the outputs and places the boundary register in the scan path. Reserved codes act as bypass.

Top module: `tapCtrl`

## Requirements
- R1: While `powerOnRst` is high and after it falls, the controller is in Test-Logic-Reset, the active instruction is IDCODE (3'b001), `tdoEnable` and `tdo` are 0, and `outputDisable` is 0.
- R2: The controller follows the standard sixteen-state transitions on each rising `tck` edge as directed by `tms`, including the Pause/Exit2 loops, which resume shifting without loss of data.
- R3: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. One clock spent in that state restores IDCODE as the active instruction.
- R4: `tdo` and `tdoEnable` change only on falling `tck` edges. `tdoEnable` is 1 exactly in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdoEnable` is 0.
- R5: Capture-IR loads 3'b001 into the instruction shift path, which shifts out least significant bit first. The active instruction changes only on the edge that leaves Update-IR, or in Test-Logic-Reset.
- R6: IDCODE (001) selects the 32-bit identification register. The register holds the revision in [31:28], the part number in [27:12] and the vendor code in [11:1], with bit 0 fixed at 1. Its default value is 32'h0000D021, and it shifts out bit 0 first.
- R7: BYPASS (111) and the reserved codes 011, 101 and 110 select a 1-bit register. That register captures 0 and passes `tdi` to `tdo` with one stage of delay.
- R8: SAMPLE (100) loads `pinCapture` into the boundary register in Capture-DR. Index 0 is nearest `tdo` and shifts out first. `tdi` enters at the far end, so it reappears after BOUND_LEN shifts.
- R9: EXTEST (000) gives the same boundary-register behaviour as SAMPLE, and `outputDisable` is 1 while that code is active.
- R10: SAMPLE-Z (010) sets `outputDisable` to 1 and selects the boundary register for capture and shift.
- R11: `outputDisable` is 0 while IDCODE, SAMPLE, BYPASS or any reserved code is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| powerOnRst | input | 1 | Chip power-on indication, active high, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in, sampled on rising `tck` |
| pinCapture | input | BOUND_LEN | Parallel pin values loaded into the boundary register |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdoEnable | output | 1 | High while a shift state drives `tdo` |
| outputDisable | output | 1 | Forces the functional data outputs to high impedance |

## Verification
The hardest case to reach from the ports is a five-clock reset that starts in the middle of a scan. At that point a tri-stating instruction is active and data is partly shifted. The output-disable line must then drop only after the extra clock spent in Test-Logic-Reset. The stimulus loads SAMPLE-Z, enters Shift-DR and holds `tms` high. A behavioural model in the bench predicts `tdo`, `tdoEnable` and `outputDisable` on every clock. A second hard case is a DR scan interrupted through Pause-DR and Exit2-DR, where the bypass bit shifted in before the pause must appear on `tdo` when shifting resumes.

// File: rtl/tapPkg.sv
package tapPkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_IDLE,
    ST_SEL_DR,
    ST_CAP_DR,
    ST_SHIFT_DR,
    ST_EXIT1_DR,
    ST_PAUSE_DR,
    ST_EXIT2_DR,
    ST_UPD_DR,
    ST_SEL_IR,
    ST_CAP_IR,
    ST_SHIFT_IR,
    ST_EXIT1_IR,
    ST_PAUSE_IR,
    ST_EXIT2_IR,
    ST_UPD_IR
  } tapState_e;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    SEL_BYPASS,
    SEL_IDENT,
    SEL_BOUNDARY
  } drSel_e;

  typedef struct packed {
    logic inReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
  } tapStrobes_t;

  function automatic drSel_e decodeSel(input logic [IR_W-1:0] op);
    drSel_e sel;
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: sel = SEL_BOUNDARY;
      OP_IDCODE:                        sel = SEL_IDENT;
      default:                          sel = SEL_BYPASS;
    endcase
    return sel;
  endfunction

  function automatic logic disablesOutputs(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
  endfunction

endpackage

// File: rtl/tapFsm.sv
module tapFsm
  import tapPkg::*;
(
  input  logic        tck,
  input  logic        powerOnRst,
  input  logic        tms,
  output tapState_e   curState,
  output tapStrobes_t strobe
);

  tapState_e nextState;

  always_comb begin
    nextState = curState;
    case (curState)
      ST_RESET:    nextState = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   nextState = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_SHIFT_DR: nextState = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
      ST_EXIT1_DR: nextState = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: nextState = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
      ST_EXIT2_DR: nextState = tms ? ST_UPD_DR   : ST_SHIFT_DR;
      ST_UPD_DR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   nextState = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_SHIFT_IR: nextState = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
      ST_EXIT1_IR: nextState = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: nextState = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
      ST_EXIT2_IR: nextState = tms ? ST_UPD_IR   : ST_SHIFT_IR;
      ST_UPD_IR:   nextState = tms ? ST_SEL_DR   : ST_IDLE;
      default:     nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst) curState <= ST_RESET;
    else            curState <= nextState;
  end

  always_comb begin
    strobe.inReset   = (curState == ST_RESET);
    strobe.captureIr = (curState == ST_CAP_IR);
    strobe.shiftIr   = (curState == ST_SHIFT_IR);
    strobe.updateIr  = (curState == ST_UPD_IR);
    strobe.captureDr = (curState == ST_CAP_DR);
    strobe.shiftDr   = (curState == ST_SHIFT_DR);
  end

endmodule

// File: rtl/tapDatapath.sv
module tapDatapath
  import tapPkg::*;
#(
  parameter int                BOUND_LEN = 107,
  parameter logic [ID_W-1:0]   ID_WORD   = 32'h0000D021
) (
  input  logic                 tck,
  input  logic                 powerOnRst,
  input  logic                 tdi,
  input  tapStrobes_t          strobe,
  input  logic [BOUND_LEN-1:0] pinCapture,
  output logic                 tdo,
  output logic                 tdoEnable,
  output logic                 outputDisable,
  output logic [IR_W-1:0]      irCur,
  output logic [IR_W-1:0]      irShift
);

  drSel_e               drSel;
  logic                 bypassBit;
  logic [ID_W-1:0]      identReg;
  logic [BOUND_LEN-1:0] boundReg;
  logic                 tdoNext;
  logic                 drOut;

  // Instruction path: shift stage plus active copy
  always_ff @(posedge tck) begin
    if (strobe.captureIr)    irShift <= IR_CAPTURE;
    else if (strobe.shiftIr) irShift <= {tdi, irShift[IR_W-1:1]};
  end

  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)           irCur <= OP_IDCODE;
    else if (strobe.inReset)  irCur <= OP_IDCODE;
    else if (strobe.updateIr) irCur <= irShift;
  end

  assign drSel         = decodeSel(irCur);
  assign outputDisable = disablesOutputs(irCur);

  // Data registers, each active only when selected
  always_ff @(posedge tck) begin
    if (drSel == SEL_BYPASS) begin
      if (strobe.captureDr)    bypassBit <= 1'b0;
      else if (strobe.shiftDr) bypassBit <= tdi;
    end
  end

  always_ff @(posedge tck) begin
    if (drSel == SEL_IDENT) begin
      if (strobe.captureDr)    identReg <= ID_WORD;
      else if (strobe.shiftDr) identReg <= {tdi, identReg[ID_W-1:1]};
    end
  end

  generate
    if (BOUND_LEN > 1) begin : gBoundLong
      always_ff @(posedge tck) begin
        if (drSel == SEL_BOUNDARY) begin
          if (strobe.captureDr)    boundReg <= pinCapture;
          else if (strobe.shiftDr) boundReg <= {tdi, boundReg[BOUND_LEN-1:1]};
        end
      end
    end else begin : gBoundOne
      always_ff @(posedge tck) begin
        if (drSel == SEL_BOUNDARY) begin
          if (strobe.captureDr)    boundReg <= pinCapture;
          else if (strobe.shiftDr) boundReg <= tdi;
        end
      end
    end
  endgenerate

  always_comb begin
    case (drSel)
      SEL_IDENT:    drOut = identReg[0];
      SEL_BOUNDARY: drOut = boundReg[0];
      default:      drOut = bypassBit;
    endcase
  end

  always_comb begin
    if (strobe.shiftIr)      tdoNext = irShift[0];
    else if (strobe.shiftDr) tdoNext = drOut;
    else                     tdoNext = 1'b0;
  end

  // Serial output retimed to the falling edge
  always_ff @(negedge tck or posedge powerOnRst) begin
    if (powerOnRst) begin
      tdo       <= 1'b0;
      tdoEnable <= 1'b0;
    end else begin
      tdo       <= tdoNext;
      tdoEnable <= strobe.shiftIr | strobe.shiftDr;
    end
  end

endmodule

// File: rtl/tapCtrl.sv
module tapCtrl
  import tapPkg::*;
#(
  parameter int          BOUND_LEN   = 107,
  parameter logic [3:0]  ID_REVISION = 4'h0,
  parameter logic [15:0] ID_PART     = 16'h000D,
  parameter logic [10:0] ID_VENDOR   = 11'h010
) (
  input  logic                 tck,
  input  logic                 powerOnRst,
  input  logic                 tms,
  input  logic                 tdi,
  input  logic [BOUND_LEN-1:0] pinCapture,
  output logic                 tdo,
  output logic                 tdoEnable,
  output logic                 outputDisable
);

  localparam logic [ID_W-1:0] ID_WORD = {ID_REVISION, ID_PART, ID_VENDOR, 1'b1};

  tapState_e       curState;
  tapStrobes_t     strobe;
  logic [IR_W-1:0] irCur;
  logic [IR_W-1:0] irShift;

  tapFsm u_fsm (
    .tck        (tck),
    .powerOnRst (powerOnRst),
    .tms        (tms),
    .curState   (curState),
    .strobe     (strobe)
  );

  tapDatapath #(
    .BOUND_LEN (BOUND_LEN),
    .ID_WORD   (ID_WORD)
  ) u_dp (
    .tck           (tck),
    .powerOnRst    (powerOnRst),
    .tdi           (tdi),
    .strobe        (strobe),
    .pinCapture    (pinCapture),
    .tdo           (tdo),
    .tdoEnable     (tdoEnable),
    .outputDisable (outputDisable),
    .irCur         (irCur),
    .irShift       (irShift)
  );

endmodule

// File: rtl/tapCtrl_checker.sv
module tapCtrl_checker
  import tapPkg::*;
(
  input logic            tck,
  input logic            powerOnRst,
  input logic            tms,
  input logic            tdo,
  input logic            tdoEnable,
  input logic            outputDisable,
  input tapState_e       curState,
  input logic [IR_W-1:0] irCur,
  input logic [IR_W-1:0] irShift
);

  logic [2:0] highRun;

  always_ff @(posedge tck or posedge powerOnRst) begin
    if (powerOnRst)         highRun <= 3'd0;
    else if (!tms)          highRun <= 3'd0;
    else if (highRun != 5)  highRun <= highRun + 3'd1;
  end

  assert_quiet_tdo_R4: assert property (@(posedge tck) disable iff (powerOnRst)
    !tdoEnable |-> !tdo);

  assert_shift_drives_R4: assert property (@(posedge tck) disable iff (powerOnRst)
    (curState == ST_SHIFT_DR || curState == ST_SHIFT_IR) |-> tdoEnable);

  assert_five_high_reset_R3: assert property (@(posedge tck) disable iff (powerOnRst)
    (highRun == 3'd5) |-> (curState == ST_RESET));

  assert_reset_idcode_R1: assert property (@(posedge tck) disable iff (powerOnRst)
    (curState == ST_RESET) |=> (irCur == OP_IDCODE));

  assert_ir_holds_R5: assert property (@(posedge tck) disable iff (powerOnRst)
    (curState != ST_UPD_IR && curState != ST_RESET) |=> $stable(irCur));

  assert_extest_tristate_R9: assert property (@(posedge tck) disable iff (powerOnRst)
    (curState == ST_UPD_IR && irShift == OP_EXTEST) |=> outputDisable);

  assert_samplez_tristate_R10: assert property (@(posedge tck) disable iff (powerOnRst)
    (curState == ST_UPD_IR && irShift == OP_SAMPLEZ) |=> outputDisable);

  assert_sample_drives_R11: assert property (@(posedge tck) disable iff (powerOnRst)
    (curState == ST_UPD_IR && irShift == OP_SAMPLE) |=> !outputDisable);

endmodule

bind tapCtrl tapCtrl_checker u_chk (
  .tck           (tck),
  .powerOnRst    (powerOnRst),
  .tms           (tms),
  .tdo           (tdo),
  .tdoEnable     (tdoEnable),
  .outputDisable (outputDisable),
  .curState      (curState),
  .irCur         (irCur),
  .irShift       (irShift)
);

// File: tb/tapCtrl_bench.sv
module tapCtrl_bench;

  localparam int BL = 107;

  logic          tck = 1'b0;
  logic          powerOnRst = 1'b1;
  logic          tms = 1'b1;
  logic          tdi = 1'b1;
  logic [BL-1:0] pins = '0;
  logic          tdo, tdoEnable, outputDisable;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curTag = "R1";

  // Behavioural model
  int mState;
  int mIr;
  bit irQ[$];
  bit drQ[$];

  always #5 tck = ~tck;

  tapCtrl #(.BOUND_LEN(BL)) u_tapCtrl (
    .tck(tck), .powerOnRst(powerOnRst), .tms(tms), .tdi(tdi),
    .pinCapture(pins), .tdo(tdo), .tdoEnable(tdoEnable),
    .outputDisable(outputDisable)
  );

  // State numbering of the model (independent of the design)
  localparam int M_TLR = 0, M_RTI = 1, M_SDR = 2, M_CDR = 3, M_SHDR = 4,
                 M_E1DR = 5, M_PDR = 6, M_E2DR = 7, M_UDR = 8, M_SIR = 9,
                 M_CIR = 10, M_SHIR = 11, M_E1IR = 12, M_PIR = 13,
                 M_E2IR = 14, M_UIR = 15;

  function automatic int nextSt(int s, bit t);
    case (s)
      M_TLR:  return t ? M_TLR  : M_RTI;
      M_RTI:  return t ? M_SDR  : M_RTI;
      M_SDR:  return t ? M_SIR  : M_CDR;
      M_CDR:  return t ? M_E1DR : M_SHDR;
      M_SHDR: return t ? M_E1DR : M_SHDR;
      M_E1DR: return t ? M_UDR  : M_PDR;
      M_PDR:  return t ? M_E2DR : M_PDR;
      M_E2DR: return t ? M_UDR  : M_SHDR;
      M_UDR:  return t ? M_SDR  : M_RTI;
      M_SIR:  return t ? M_TLR  : M_CIR;
      M_CIR:  return t ? M_E1IR : M_SHIR;
      M_SHIR: return t ? M_E1IR : M_SHIR;
      M_E1IR: return t ? M_UIR  : M_PIR;
      M_PIR:  return t ? M_E2IR : M_PIR;
      M_E2IR: return t ? M_UIR  : M_SHIR;
      default: return t ? M_SDR : M_RTI;
    endcase
  endfunction

  task automatic modelEdge(bit t, bit d);
    case (mState)
      M_TLR: mIr = 1;
      M_CIR: begin irQ.delete(); irQ.push_back(1); irQ.push_back(0); irQ.push_back(0); end
      M_SHIR: begin void'(irQ.pop_front()); irQ.push_back(d); end
      M_UIR: mIr = irQ[0] + 2 * irQ[1] + 4 * irQ[2];
      M_CDR: begin
        drQ.delete();
        if (mIr == 0 || mIr == 2 || mIr == 4) begin
          for (int i = 0; i < BL; i++) drQ.push_back(pins[i]);
        end else if (mIr == 1) begin
          logic [31:0] idv = 32'h0000D021;
          for (int i = 0; i < 32; i++) drQ.push_back(idv[i]);
        end else drQ.push_back(0);
      end
      M_SHDR: begin void'(drQ.pop_front()); drQ.push_back(d); end
      default: ;
    endcase
    mState = nextSt(mState, t);
  endtask

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compareOutputs();
    bit eEn, eTdo, eDis;
    eEn  = (mState == M_SHIR) || (mState == M_SHDR);
    eTdo = (mState == M_SHIR) ? irQ[0] : (mState == M_SHDR) ? drQ[0] : 1'b0;
    eDis = (mIr == 0) || (mIr == 2);
    // R4 timing and R11/R9/R10 levels compared on every clock
    check({tdo, tdoEnable, outputDisable} === {eTdo, eEn, eDis}, curTag,
          {tdo, tdoEnable, outputDisable}, {eTdo, eEn, eDis});
  endtask

  task automatic clk(bit t, bit d);
    tms = t;
    tdi = d;
    @(posedge tck);
    modelEdge(t, d);
    @(negedge tck);
    #1;
    compareOutputs();
  endtask

  task automatic scanIr(input logic [2:0] op, output logic [2:0] cap);
    clk(1, 1); clk(1, 1); clk(0, 1); clk(0, 1);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      clk(i == 2, op[i]);
    end
    clk(1, 1); clk(0, 1);
  endtask

  task automatic scanDr(input int n, input logic [127:0] din, output logic [127:0] dout);
    dout = '0;
    clk(1, 1); clk(0, 1); clk(0, 1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      clk(i == n - 1, din[i]);
    end
    clk(1, 1); clk(0, 1);
  endtask

  task automatic setPins(int seed);
    for (int i = 0; i < BL; i++) pins[i] = (((i * 7 + seed) % 3) == 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]   cap;
    logic [127:0] dout;
    logic [127:0] din;
    logic [127:0] expB;
    mState = M_TLR;
    mIr = 1;
    repeat (3) @(posedge tck);
    @(negedge tck);
    powerOnRst = 1'b0;
    #1;
    // R1: quiet outputs straight after power-on
    check({tdo, tdoEnable, outputDisable} == 3'b000, "R1", {tdo, tdoEnable, outputDisable}, 0);
    clk(1, 1); clk(0, 1);

    // R5: capture pattern and deferred update
    curTag = "R5";
    scanIr(3'b100, cap);
    check(cap == 3'b001, "R5", cap, 3'b001);

    // R8: SAMPLE captures pins, tdi re-emerges after BL shifts
    curTag = "R8";
    setPins(1);
    din = {4{32'hA5C3_1E97}};
    scanDr(BL + 8, din, dout);
    check(dout[BL-1:0] == pins, "R8", dout[BL-1:0], pins);
    check(dout[BL+7:BL] == din[7:0], "R8", dout[BL+7:BL], din[7:0]);
    check(outputDisable == 1'b0, "R11", outputDisable, 0);

    // R3 + R6: five-high reset then identification
    curTag = "R3";
    repeat (5) clk(1, 1);
    clk(0, 1);
    check(outputDisable == 1'b0 && tdoEnable == 1'b0, "R3", {outputDisable, tdoEnable}, 0);
    curTag = "R6";
    scanDr(32, '1, dout);
    check(dout[31:0] == 32'h0000D021, "R6", dout[31:0], 32'h0000D021);

    // R7/R11: bypass and the reserved codes
    foreach (cap[k]) ;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] op;
      op = (k == 0) ? 3'b111 : (k == 1) ? 3'b011 : (k == 2) ? 3'b101 : 3'b110;
      curTag = "R7";
      scanIr(op, cap);
      check(outputDisable == 1'b0, "R11", outputDisable, 0);
      scanDr(4, 128'b1011, dout);
      check(dout[3:0] == 4'b0110, "R7", dout[3:0], 4'b0110);
    end

    // R2: pause/exit2 loop keeps the bypass bit
    curTag = "R2";
    clk(1, 1); clk(0, 1); clk(0, 1);
    clk(1, 1);
    clk(0, 0); clk(0, 0); clk(1, 0); clk(0, 0);
    check(tdoEnable == 1'b1 && tdo == 1'b1, "R2", {tdoEnable, tdo}, 2'b11);
    clk(1, 0); clk(1, 0); clk(0, 0);

    // R9: EXTEST disables outputs and captures pins
    curTag = "R9";
    scanIr(3'b000, cap);
    check(outputDisable == 1'b1, "R9", outputDisable, 1);
    setPins(2);
    expB = '0;
    expB[BL-1:0] = pins;
    scanDr(BL, '0, dout);
    check(dout[BL-1:0] == expB[BL-1:0], "R9", dout[BL-1:0], expB[BL-1:0]);

    // R10: SAMPLE-Z, then reset from the middle of a scan
    curTag = "R10";
    scanIr(3'b010, cap);
    check(outputDisable == 1'b1, "R10", outputDisable, 1);
    setPins(0);
    expB[BL-1:0] = pins;
    scanDr(BL, '0, dout);
    check(dout[BL-1:0] == expB[BL-1:0], "R10", dout[BL-1:0], expB[BL-1:0]);
    clk(1, 1); clk(0, 1); clk(0, 1);
    curTag = "R3";
    repeat (5) clk(1, 1);
    check(outputDisable == 1'b1, "R3", outputDisable, 1);
    clk(1, 1);
    check(outputDisable == 1'b0 && tdoEnable == 1'b0, "R3", {outputDisable, tdoEnable}, 0);
    clk(0, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule